// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether an Ethernet frame's destination address is accepted by a receiver. The destination address arrives as six bytes on a byte stream. The first byte is marked by a start strobe, and idle cycles may fall between bytes. While the bytes arrive, the block folds each one into a byte-serial CRC-32. It also keeps a copy of the whole address.

One cycle after the sixth byte, the block gives a single-cycle decision pulse with an accept bit. The decision comes from these rules:
- a promiscuous switch;
- a master filter enable;
- broadcast acceptance;
- multicast acceptance, with or without a 64-bit hash table held as two 32-bit words;
- an exact match of the address against the station address.

The hash table index is the top six bits of the big-endian CRC-32 of the address. The upper index bit chooses the hash word and the lower five choose a bit within it. Frame storage and the check of the full-frame CRC belong to neighbouring blocks.

Top module: `mac_dest_filter`

## Requirements
- R1: After reset, and until a complete address has been received, dec_valid and dec_accept are 0.
- R2: A byte counts when byte_valid is 1. addr_start=1 together with byte_valid=1 marks the first byte. The byte that completes the sixth counted byte is taken at a clock edge, and from that edge dec_valid is 1 for exactly one cycle. dec_accept is 0 whenever dec_valid is 0.
- R3: Idle cycles between the bytes of one address do not change the result. Bytes that arrive while no address is in progress and without addr_start are ignored and produce no decision. A new addr_start in the middle of an address discards the partial address and starts again.
- R4: When promisc=1, every address is accepted.
- R5: When promisc=0 and da_filt_en=0, every address is accepted.
- R6: When filtering applies (promisc=0, da_filt_en=1), an address with all 48 bits set to 1 is a broadcast. A broadcast is accepted exactly when bc_en=1.
- R7: With filtering on, an address that is not broadcast and has bit 0 of its first byte set is multicast. A multicast address is handled as follows:
  - with mc_en=0 it is rejected;
  - with mc_en=1 and hash_en=0 it is accepted;
  - with mc_en=1 and hash_en=1 it is accepted exactly when the selected hash bit is 1.
- R8: The hash index is bits 31:26 of a CRC-32 computed as follows. The register starts at 0xFFFFFFFF. Bytes are taken first to last, each least significant bit first. For each bit, shift left and XOR with 0x04C11DB7 when the old bit 31 XOR the data bit is 1. There is no final inversion. Index bit 5 = 0 selects hash_w0 and 1 selects hash_w1. Index bits 4:0 select the bit within the chosen word.
- R9: With filtering on, a unicast address is handled as follows:
  - with uc_match_en=0 it is accepted;
  - with uc_match_en=1 it is accepted only when it equals the station address {sta_hi, sta_lo}, where sta_hi[23:16] is the first byte received and sta_lo[7:0] is the sixth.
- R10: When both hash words are all ones, with mc_en=1 and hash_en=1, every multicast address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | byte_data holds an address byte this cycle |
| addr_start | input | 1 | Marks the current byte as the first byte of an address |
| byte_data | input | 8 | Address byte |
| sta_hi | input | 24 | Station address, bytes 0..2, with byte 0 in the top bits |
| sta_lo | input | 24 | Station address, bytes 3..5, with byte 3 in the top bits |
| hash_w0 | input | 32 | Hash table, indices 0..31 |
| hash_w1 | input | 32 | Hash table, indices 32..63 |
| uc_match_en | input | 1 | Unicast addresses must match the station address |
| da_filt_en | input | 1 | Master enable for destination filtering |
| mc_en | input | 1 | Accept multicast addresses |
| hash_en | input | 1 | Multicast acceptance also requires a hash hit |
| bc_en | input | 1 | Accept broadcast |
| promisc | input | 1 | Accept everything |
| dec_valid | output | 1 | Single-cycle decision strobe |
| dec_accept | output | 1 | Decision, meaningful while dec_valid is 1 |

## Verification
The bench sweeps all 64 combinations of the mode bits against a broadcast, a multicast, a matching unicast and a mismatching unicast address. This exposes a rule applied in the wrong priority: for example, a broadcast treated as an ordinary multicast would be accepted through the hash path even with bc_en cleared.

A second sweep runs over more than a hundred multicast addresses. For each one, the bench sets only the hash bit it computes for that address, or only its neighbour. A CRC with the bit order reversed, an index taken from the wrong end of the register, or swapped hash words would then accept the wrong members of each pair.

Further runs use idle gaps, stray bytes and a restart in the middle of an address. These catch a byte counter that advances on idle cycles or that ignores a second start strobe.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;

  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  // Folds one byte, least significant bit first, into a left-shifting CRC.
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] crc_in,
                                                      input logic [7:0] data);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_in;
    for (int b = 0; b < 8; b++) begin
      fb = c[CRC_W-1] ^ data[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/dfilt_seq.sv
module dfilt_seq #(
  parameter int ADDR_BYTES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_valid,
  input  logic addr_start,
  output logic take_first,
  output logic take_next,
  output logic done_q
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active_q, active_d;
  logic             last_byte;

  always_comb begin
    take_first = byte_valid & addr_start;
    take_next  = byte_valid & ~addr_start & active_q;
    last_byte  = (take_first && (ADDR_BYTES == 1)) ||
                 (take_next && (cnt_q == CNT_W'(ADDR_BYTES - 1)));
    cnt_d    = cnt_q;
    active_d = active_q;
    if (take_first) begin
      cnt_d    = CNT_W'(1);
      active_d = ~last_byte;
    end else if (take_next) begin
      cnt_d    = cnt_q + CNT_W'(1);
      active_d = ~last_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_byte;
      if (take_first | take_next) begin
        cnt_q    <= cnt_d;
        active_q <= active_d;
      end
    end
  end
endmodule

// File: rtl/dfilt_crc.sv
module dfilt_crc
  import dfilt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_first,
  input  logic             take_next,
  input  logic [7:0]       byte_data,
  output logic [CRC_W-1:0] crc_q
);
  logic [CRC_W-1:0] crc_d;
  logic             crc_en;

  always_comb begin
    crc_en = take_first | take_next;
    crc_d  = crc_fold_byte(take_first ? CRC_SEED : crc_q, byte_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end
endmodule

// File: rtl/dfilt_addr.sv
module dfilt_addr #(
  parameter int ADDR_BYTES = 6,
  localparam int AW = ADDR_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_first,
  input  logic          take_next,
  input  logic [7:0]    byte_data,
  output logic [AW-1:0] addr_q
);
  logic [AW-1:0] addr_d;
  logic          addr_en;

  generate
    if (ADDR_BYTES > 1) begin : g_shift
      always_comb addr_d = {addr_q[AW-9:0], byte_data};
    end else begin : g_single
      always_comb addr_d = byte_data;
    end
  endgenerate

  always_comb addr_en = take_first | take_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end
endmodule

// File: rtl/dfilt_decide.sv
module dfilt_decide #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_IDX_W = 6,
  localparam int AW     = ADDR_BYTES * 8,
  localparam int WORD_W = 1 << (HASH_IDX_W - 1)
) (
  input  logic                  done,
  input  logic [AW-1:0]         addr,
  input  logic [HASH_IDX_W-1:0] hash_idx,
  input  logic [AW-1:0]         station,
  input  logic [WORD_W-1:0]     hash_w0,
  input  logic [WORD_W-1:0]     hash_w1,
  input  logic                  uc_match_en,
  input  logic                  da_filt_en,
  input  logic                  mc_en,
  input  logic                  hash_en,
  input  logic                  bc_en,
  input  logic                  promisc,
  output logic                  accept
);
  logic [HASH_IDX_W-2:0] bit_sel;
  logic                  hash_hit, is_bc, is_mc, verdict;

  always_comb begin
    bit_sel  = hash_idx[HASH_IDX_W-2:0];
    hash_hit = hash_idx[HASH_IDX_W-1] ? hash_w1[bit_sel] : hash_w0[bit_sel];
    is_bc    = &addr;
    is_mc    = addr[AW-8];
    if (promisc)          verdict = 1'b1;
    else if (!da_filt_en) verdict = 1'b1;
    else if (is_bc)       verdict = bc_en;
    else if (is_mc)       verdict = mc_en & (~hash_en | hash_hit);
    else                  verdict = ~uc_match_en | (addr == station);
    accept = done & verdict;
  end
endmodule

// File: rtl/mac_dest_filter.sv
module mac_dest_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_IDX_W = 6,
  localparam int AW     = ADDR_BYTES * 8,
  localparam int HALF_W = AW / 2,
  localparam int WORD_W = 1 << (HASH_IDX_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic              addr_start,
  input  logic [7:0]        byte_data,
  input  logic [HALF_W-1:0] sta_hi,
  input  logic [HALF_W-1:0] sta_lo,
  input  logic [WORD_W-1:0] hash_w0,
  input  logic [WORD_W-1:0] hash_w1,
  input  logic              uc_match_en,
  input  logic              da_filt_en,
  input  logic              mc_en,
  input  logic              hash_en,
  input  logic              bc_en,
  input  logic              promisc,
  output logic              dec_valid,
  output logic              dec_accept
);
  import dfilt_pkg::*;

  logic                  take_first, take_next, done_q;
  logic [CRC_W-1:0]      crc_q;
  logic [AW-1:0]         addr_q;
  logic [HASH_IDX_W-1:0] hash_idx;

  dfilt_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .addr_start(addr_start),
    .take_first(take_first), .take_next(take_next), .done_q(done_q));

  dfilt_crc u_crc (
    .clk(clk), .rst_n(rst_n), .take_first(take_first), .take_next(take_next),
    .byte_data(byte_data), .crc_q(crc_q));

  dfilt_addr #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .take_first(take_first), .take_next(take_next),
    .byte_data(byte_data), .addr_q(addr_q));

  assign hash_idx = crc_q[CRC_W-1 -: HASH_IDX_W];

  dfilt_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_IDX_W(HASH_IDX_W)) u_decide (
    .done(done_q), .addr(addr_q), .hash_idx(hash_idx), .station({sta_hi, sta_lo}),
    .hash_w0(hash_w0), .hash_w1(hash_w1), .uc_match_en(uc_match_en),
    .da_filt_en(da_filt_en), .mc_en(mc_en), .hash_en(hash_en), .bc_en(bc_en),
    .promisc(promisc), .accept(dec_accept));

  assign dec_valid = done_q;
endmodule

// File: rtl/dfilt_checker.sv
module dfilt_checker #(
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_valid,
  input logic          dec_valid,
  input logic          dec_accept,
  input logic          promisc,
  input logic          da_filt_en,
  input logic          bc_en,
  input logic [AW-1:0] addr_q
);
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(byte_valid));

  assert_accept_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);

  assert_promisc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && promisc) |-> dec_accept);

  assert_no_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !promisc && !da_filt_en) |-> dec_accept);

  assert_broadcast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !promisc && da_filt_en && (&addr_q)) |-> (dec_accept == bc_en));
endmodule

bind mac_dest_filter dfilt_checker #(.AW(AW)) u_dfilt_checker (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .promisc(promisc), .da_filt_en(da_filt_en),
  .bc_en(bc_en), .addr_q(addr_q));

// File: tb/mac_dest_filter_bench.sv
module mac_dest_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, byte_valid, addr_start;
  logic [7:0]  byte_data;
  logic [23:0] sta_hi, sta_lo;
  logic [31:0] hash_w0, hash_w1;
  logic        uc_match_en, da_filt_en, mc_en, hash_en, bc_en, promisc;
  logic        dec_valid, dec_accept;

  int checks = 0;
  int errors = 0;

  mac_dest_filter u_mac_dest_filter (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .addr_start(addr_start),
    .byte_data(byte_data), .sta_hi(sta_hi), .sta_lo(sta_lo), .hash_w0(hash_w0),
    .hash_w1(hash_w1), .uc_match_en(uc_match_en), .da_filt_en(da_filt_en),
    .mc_en(mc_en), .hash_en(hash_en), .bc_en(bc_en), .promisc(promisc),
    .dec_valid(dec_valid), .dec_accept(dec_accept));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Hash index per R8, computed independently of the design.
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++) begin
        fb = c[31] ^ a[47 - 8*k - 7 + b];
        c  = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return c[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    logic [5:0] ix;
    logic       hit;
    ix  = ref_idx(a);
    hit = ix[5] ? hash_w1[ix[4:0]] : hash_w0[ix[4:0]];
    if (promisc)          return 1'b1;             // R4
    if (!da_filt_en)      return 1'b1;             // R5
    if (a == '1)          return bc_en;            // R6
    if (a[40])            return mc_en & (!hash_en | hit);  // R7
    return !uc_match_en | (a == {sta_hi, sta_lo}); // R9
  endfunction

  task automatic set_modes(input logic [5:0] m);
    {promisc, bc_en, hash_en, mc_en, da_filt_en, uc_match_en} = m;
  endtask

  // Sends six bytes starting at a negedge, then checks the decision (R2).
  task automatic send(input logic [47:0] a, input int gap, input string req);
    logic exp;
    exp = ref_accept(a);
    for (int k = 0; k < 6; k++) begin
      byte_valid = 1'b1;
      addr_start = (k == 0);
      byte_data  = a[47 - 8*k -: 8];
      @(negedge clk);
      if (k < 5) begin
        byte_valid = 1'b0;
        addr_start = 1'b0;
        byte_data  = 8'hA5;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          chk("R2 no early strobe", dec_valid, 1'b0);
        end
      end
    end
    chk("R2 strobe", dec_valid, 1'b1);
    chk(req, dec_accept, exp);
    byte_valid = 1'b0;
    addr_start = 1'b0;
    @(negedge clk);
    chk("R2 single cycle", dec_valid, 1'b0);
    chk("R2 accept gated", dec_accept, 1'b0);
  endtask

  logic [47:0] bc_addr, mc_addr, uc_hit, uc_miss, a;
  logic [31:0] lcg;
  logic [5:0]  ix;

  initial begin
    rst_n = 1'b0; byte_valid = 1'b0; addr_start = 1'b0; byte_data = 8'h00;
    sta_hi = 24'h02_1A_3C; sta_lo = 24'h5E_77_90;
    hash_w0 = 32'h0; hash_w1 = 32'h0;
    set_modes(6'b000000);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset valid", dec_valid, 1'b0);
    chk("R1 reset accept", dec_accept, 1'b0);

    // R3: bytes without a start are ignored.
    for (int k = 0; k < 10; k++) begin
      byte_valid = 1'b1; byte_data = 8'(k * 17);
      @(negedge clk);
      chk("R3 stray byte ignored", dec_valid, 1'b0);
    end
    byte_valid = 1'b0;
    @(negedge clk);
    chk("R3 stray byte ignored", dec_valid, 1'b0);

    // R3: restart in the middle discards the partial address.
    set_modes(6'b000011);
    for (int k = 0; k < 3; k++) begin
      byte_valid = 1'b1; addr_start = (k == 0); byte_data = 8'hC0 + 8'(k);
      @(negedge clk);
    end
    send({sta_hi, sta_lo}, 0, "R3 restart then matching unicast");
    send({sta_hi, sta_lo}, 3, "R3 gaps between bytes");

    // Mode sweep (R4..R7, R9).
    bc_addr = '1;
    mc_addr = 48'h01_00_5E_12_34_56;
    uc_hit  = {sta_hi, sta_lo};
    uc_miss = {sta_hi, sta_lo ^ 24'h000100};
    ix = ref_idx(mc_addr);
    hash_w0 = 32'h0; hash_w1 = 32'h0;
    if (ix[5]) hash_w1[ix[4:0]] = 1'b1; else hash_w0[ix[4:0]] = 1'b1;
    for (int m = 0; m < 64; m++) begin
      set_modes(6'(m));
      send(bc_addr, m % 2, "R6 broadcast");
      send(mc_addr, 0, "R7 multicast");
      send(uc_hit, 0, "R9 unicast match");
      send(uc_miss, 1, "R9 unicast mismatch");
    end

    // Hash sweep (R8): only the computed bit, or only its neighbour.
    set_modes(6'b001111);
    lcg = 32'h1234_5678;
    for (int i = 0; i < 128; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      a[47:24] = lcg[31:8];
      lcg = lcg * 32'd1103515245 + 32'd12345;
      a[23:0] = lcg[31:8];
      a[40] = 1'b1;
      if (a == '1) a[0] = 1'b0;
      ix = ref_idx(a);
      if (i % 2 == 1) ix[0] = ~ix[0];
      if (i % 4 >= 2) ix[5] = ~ix[5];
      hash_w0 = 32'h0; hash_w1 = 32'h0;
      if (ix[5]) hash_w1[ix[4:0]] = 1'b1; else hash_w0[ix[4:0]] = 1'b1;
      send(a, 0, "R8 hash bit select");
    end

    // R10: all-ones table passes every multicast.
    hash_w0 = '1; hash_w1 = '1;
    for (int i = 0; i < 16; i++) begin
      a = {8'h01 | 8'(i << 1), 8'(i * 7), 8'h55, 8'(i), 8'hAA, 8'(i * 3)};
      send(a, 0, "R10 all-multicast");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule